// File: doc/BRIEF.md
# Last-Branch Record Ring Stack

This block keeps a circular history of the most recent control transfers a core has taken: taken branches, interrupts and exceptions. Each history slot holds two linear addresses, the origin of the transfer and its destination. When an event arrives, a top-of-stack pointer first steps forward by one, wrapping at the last slot. The new origin/destination pair is then stored in the slot the pointer now names. The pointer therefore always names the newest record, and the slot after it (modulo depth) holds the oldest.

The core presents each event as a one-cycle pulse that carries a 2-bit kind code and every candidate address. The block picks the origin/destination pair from those addresses according to the kind. Software reaches the slots and the pointer through a read-only register port with a request/response handshake. Each request gets exactly one response on the following cycle. Write requests get a response too, but they change nothing.

Both input streams are valid/ready streams whose ready is held high, so the block never applies back-pressure. The response stream has no ready: the consumer must take `rs_valid`/`rs_data` in the cycle it appears. The stack depth `DEPTH` is a parameter and must be 4 or 16. The pointer then spans 0..3 or 0..15.

Top module: `lbr_ring_top`

## Requirements
- R1: After reset the pointer reads DEPTH-1 and every slot's origin and destination read zero.
- R2: Each accepted event with kind 0, 1 or 2 advances the pointer by one and then stores its pair in the slot the advanced pointer names; the pointer always reads the slot of the newest record.
- R3: An event accepted while the pointer is DEPTH-1 moves it to 0 and overwrites slot 0, the oldest record.
- R4: Kind 0 (branch): origin is `ev_br_addr`, destination is `ev_br_tgt`.
- R5: Kind 1 (interrupt): origin is `ev_ret_addr`, the saved return address, and destination is `ev_hdl_addr`.
- R6: Kind 2 (exception): origin is `ev_fault_addr`, destination is `ev_hdl_addr`.
- R7: An event with kind 3 is dropped: the pointer and all slots keep their values.
- R8: A request accepted in cycle n gives `rs_valid` high with data in cycle n+1, and `rs_valid` is low when there was no request. Address encoding uses `rq_addr[IDXW+1]`=1 for the pointer, which is returned zero-extended. Otherwise `rq_addr[IDXW:1]` is the slot and `rq_addr[0]` picks origin (0) or destination (1).
- R9: A request with `rq_write`=1 is answered like a read of the same address and leaves the pointer and every slot unchanged, whatever `rq_wdata` holds.
- R10: A request in the same cycle as an accepted event returns the value held before that event; the new pointer and the new record are visible to requests from the next cycle on.
- R11: `ev_ready` and `rq_ready` are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event pulse |
| ev_ready | output | 1 | Event accept, always 1 |
| ev_kind | input | 2 | 0 branch, 1 interrupt, 2 exception, 3 dropped |
| ev_br_addr | input | ADDR_W | Address of the branch instruction |
| ev_br_tgt | input | ADDR_W | Branch target |
| ev_ret_addr | input | ADDR_W | Return address saved for an interrupt |
| ev_fault_addr | input | ADDR_W | Address of the faulting instruction |
| ev_hdl_addr | input | ADDR_W | First instruction of the handler |
| rq_valid | input | 1 | Register request valid |
| rq_ready | output | 1 | Register request accept, always 1 |
| rq_write | input | 1 | Request is a write (ignored) |
| rq_addr | input | IDXW+2 | Register address |
| rq_wdata | input | ADDR_W | Write data (ignored) |
| rs_valid | output | 1 | Response valid |
| rs_data | output | ADDR_W | Response data |

## Verification
A register request and a recorded event can fall in the same clock cycle. The outcome depends on whether the read samples state before or after the update. The bench provokes this by raising `ev_valid` and `rq_valid` on the same edge. It reads both the pointer and the slot the event is about to overwrite, and expects the pre-event values. It then reads both again on the next request and expects the advanced pointer and the new pair, all computed from its own model of the ring.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [1:0] {
    XFER_BRANCH = 2'd0,
    XFER_INTR   = 2'd1,
    XFER_EXCP   = 2'd2,
    XFER_NONE   = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/lbr_pair_sel.sv
module lbr_pair_sel
  import lbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [ADDR_W-1:0] hdl_addr,
  output logic              recordable,
  output logic [ADDR_W-1:0] from_addr,
  output logic [ADDR_W-1:0] to_addr
);
  always_comb begin
    recordable = 1'b1;
    from_addr  = '0;
    to_addr    = '0;
    unique case (xfer_kind_e'(kind))
      XFER_BRANCH: begin from_addr = br_addr;    to_addr = br_tgt;   end
      XFER_INTR:   begin from_addr = ret_addr;   to_addr = hdl_addr; end
      XFER_EXCP:   begin from_addr = fault_addr; to_addr = hdl_addr; end
      default:     recordable = 1'b0;
    endcase
  end
endmodule

// File: rtl/lbr_tos_ptr.sv
module lbr_tos_ptr #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [IDXW-1:0] tos_q,
  output logic [IDXW-1:0] tos_nxt
);
  localparam logic [IDXW-1:0] TOS_LAST = IDXW'(DEPTH - 1);

  assign tos_nxt = (tos_q == TOS_LAST) ? '0 : tos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   tos_q <= TOS_LAST;
    else if (adv) tos_q <= tos_nxt;
  end
endmodule

// File: rtl/lbr_entry_bank.sv
module lbr_entry_bank #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [IDXW-1:0]   widx,
  input  logic [ADDR_W-1:0] wfrom,
  input  logic [ADDR_W-1:0] wto,
  input  logic [IDXW-1:0]   ridx,
  output logic [ADDR_W-1:0] rfrom,
  output logic [ADDR_W-1:0] rto
);
  logic [ADDR_W-1:0] from_q [DEPTH];
  logic [ADDR_W-1:0] to_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else if (wen && widx == IDXW'(g)) begin
        from_q[g] <= wfrom;
        to_q[g]   <= wto;
      end
    end
  end

  assign rfrom = from_q[ridx];
  assign rto   = to_q[ridx];
endmodule

// File: rtl/lbr_ring_top.sv
module lbr_ring_top #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int RAW  = IDXW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_br_addr,
  input  logic [ADDR_W-1:0] ev_br_tgt,
  input  logic [ADDR_W-1:0] ev_ret_addr,
  input  logic [ADDR_W-1:0] ev_fault_addr,
  input  logic [ADDR_W-1:0] ev_hdl_addr,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic              rq_write,
  input  logic [RAW-1:0]    rq_addr,
  input  logic [ADDR_W-1:0] rq_wdata,
  output logic              rs_valid,
  output logic [ADDR_W-1:0] rs_data
);
  logic              recordable, rec_fire;
  logic [ADDR_W-1:0] sel_from, sel_to, rd_from, rd_to, rd_word;
  logic [IDXW-1:0]   tos_q, tos_nxt;
  logic              unused_wr;

  assign ev_ready  = 1'b1;
  assign rq_ready  = 1'b1;
  // software writes are accepted and discarded
  assign unused_wr = rq_write ^ (^rq_wdata);

  lbr_pair_sel #(.ADDR_W(ADDR_W)) u_sel (
    .kind(ev_kind), .br_addr(ev_br_addr), .br_tgt(ev_br_tgt),
    .ret_addr(ev_ret_addr), .fault_addr(ev_fault_addr), .hdl_addr(ev_hdl_addr),
    .recordable(recordable), .from_addr(sel_from), .to_addr(sel_to)
  );

  assign rec_fire = ev_valid && recordable;

  lbr_tos_ptr #(.DEPTH(DEPTH)) u_tos (
    .clk(clk), .rst_n(rst_n), .adv(rec_fire), .tos_q(tos_q), .tos_nxt(tos_nxt)
  );

  lbr_entry_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wen(rec_fire), .widx(tos_nxt),
    .wfrom(sel_from), .wto(sel_to),
    .ridx(rq_addr[IDXW:1]), .rfrom(rd_from), .rto(rd_to)
  );

  always_comb begin
    if (rq_addr[RAW-1]) rd_word = ADDR_W'(tos_q);
    else if (rq_addr[0]) rd_word = rd_to;
    else                 rd_word = rd_from;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_data  <= '0;
    end else begin
      rs_valid <= rq_valid;
      if (rq_valid) rs_data <= rd_word;
    end
  end
endmodule

// File: rtl/lbr_ring_chk.sv
module lbr_ring_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int RAW  = IDXW + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [1:0]        ev_kind,
  input logic              rq_valid,
  input logic [RAW-1:0]    rq_addr,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_data,
  input logic [IDXW-1:0]   tos_q
);
  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind != 2'd3) |=> tos_q == IDXW'($past(tos_q) + 1'b1));

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind != 2'd3 && tos_q == IDXW'(DEPTH - 1)) |=> tos_q == '0);

  // R7
  drop_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid || ev_kind == 2'd3) |=> $stable(tos_q));

  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |=> rs_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_valid |=> !rs_valid);

  // R10
  ptr_read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_addr[RAW-1]) |=> rs_data == ADDR_W'($past(tos_q)));
endmodule

bind lbr_ring_top lbr_ring_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .rq_valid(rq_valid), .rq_addr(rq_addr), .rs_valid(rs_valid),
  .rs_data(rs_data), .tos_q(tos_q)
);

// File: tb/tb_lbr_ring_top.sv
`timescale 1ns/1ps
module tb_lbr_ring_top;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 32;
  localparam int IDXW   = $clog2(DEPTH);
  localparam int RAW    = IDXW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, rq_valid = 1'b0, rq_write = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [ADDR_W-1:0] ev_br_addr = '0, ev_br_tgt = '0, ev_ret_addr = '0;
  logic [ADDR_W-1:0] ev_fault_addr = '0, ev_hdl_addr = '0, rq_wdata = '0;
  logic [RAW-1:0] rq_addr = '0;
  logic ev_ready, rq_ready, rs_valid;
  logic [ADDR_W-1:0] rs_data;

  int checks = 0, errors = 0;
  logic [IDXW-1:0]   m_tos;
  logic [ADDR_W-1:0] m_from [DEPTH];
  logic [ADDR_W-1:0] m_to   [DEPTH];

  always #2 clk = ~clk;

  lbr_ring_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RAW-1:0] a_ptr();
    return {1'b1, {(RAW-1){1'b0}}};
  endfunction
  function automatic logic [RAW-1:0] a_slot(int idx, bit to_fld);
    return {1'b0, IDXW'(idx), to_fld};
  endfunction

  // R8: one request, response sampled one cycle later
  task automatic req(input logic [RAW-1:0] a, input bit wr,
                     input logic [ADDR_W-1:0] wd, output logic [ADDR_W-1:0] d);
    @(negedge clk);
    rq_valid = 1'b1; rq_addr = a; rq_write = wr; rq_wdata = wd;
    @(negedge clk);
    rq_valid = 1'b0; rq_write = 1'b0;
    chk("R8 rs_valid", ADDR_W'(rs_valid), 1);
    d = rs_data;
  endtask

  task automatic set_event(int n, logic [1:0] k);
    ev_valid = 1'b1; ev_kind = k;
    ev_br_addr    = 32'hB000_0000 + n;
    ev_br_tgt     = 32'hC000_0000 + (n << 4);
    ev_ret_addr   = 32'hA000_0000 + (n << 8);
    ev_fault_addr = 32'hF000_0000 + (n << 12);
    ev_hdl_addr   = 32'hD000_0000 + n * 3;
    // model update from R2..R7
    if (k != 2'd3) begin
      m_tos = (m_tos == IDXW'(DEPTH-1)) ? '0 : m_tos + 1'b1;
      case (k)
        2'd0: begin m_from[m_tos] = ev_br_addr;    m_to[m_tos] = ev_br_tgt;   end
        2'd1: begin m_from[m_tos] = ev_ret_addr;   m_to[m_tos] = ev_hdl_addr; end
        default: begin m_from[m_tos] = ev_fault_addr; m_to[m_tos] = ev_hdl_addr; end
      endcase
    end
  endtask

  task automatic post_event(int n, logic [1:0] k);
    @(negedge clk);
    set_event(n, k);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic sweep(string req_tag);
    logic [ADDR_W-1:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      req(a_slot(i, 1'b0), 1'b0, '0, d); chk({req_tag, " origin"}, d, m_from[i]);
      req(a_slot(i, 1'b1), 1'b0, '0, d); chk({req_tag, " destination"}, d, m_to[i]);
    end
    req(a_ptr(), 1'b0, '0, d); chk({req_tag, " pointer"}, d, ADDR_W'(m_tos));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] d;
    logic [IDXW-1:0] nxt;
    m_tos = IDXW'(DEPTH-1);
    for (int i = 0; i < DEPTH; i++) begin m_from[i] = '0; m_to[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11
    chk("R11 ready", ADDR_W'({ev_ready, rq_ready}), 3);
    // R1
    sweep("R1 reset");
    // R2 R3 R4 R5 R6 R7: many events over several wraps, all kinds
    for (int n = 1; n <= 13; n++) begin
      logic [1:0] k = 2'(n % 4);
      post_event(n, k);
      req(a_ptr(), 1'b0, '0, d);
      chk(k == 2'd3 ? "R7 dropped kind pointer" : "R2 R3 pointer", d, ADDR_W'(m_tos));
      if (k != 2'd3) begin
        req(a_slot(m_tos, 1'b0), 1'b0, '0, d);
        chk(k == 0 ? "R4 origin" : k == 1 ? "R5 origin" : "R6 origin", d, m_from[m_tos]);
        req(a_slot(m_tos, 1'b1), 1'b0, '0, d);
        chk(k == 0 ? "R4 destination" : k == 1 ? "R5 destination" : "R6 destination", d, m_to[m_tos]);
      end
      if (n % 5 == 0) sweep("R3 R7 ring");
    end
    // R10: request in the same cycle as an event
    nxt = (m_tos == IDXW'(DEPTH-1)) ? '0 : m_tos + 1'b1;
    begin
      logic [ADDR_W-1:0] old_ptr, old_slot;
      old_ptr  = ADDR_W'(m_tos);
      old_slot = m_from[nxt];
      @(negedge clk);
      rq_valid = 1'b1; rq_addr = a_ptr(); rq_write = 1'b0;
      set_event(20, 2'd2);
      @(negedge clk);
      ev_valid = 1'b0; rq_valid = 1'b0;
      chk("R10 same-cycle pointer old", rs_data, old_ptr);
      @(negedge clk);
      rq_valid = 1'b1; rq_addr = a_slot(m_tos == '0 ? DEPTH-1 : m_tos - 1, 1'b0);
      // next slot to be written, read together with event 21
      nxt = (m_tos == IDXW'(DEPTH-1)) ? '0 : m_tos + 1'b1;
      rq_addr = a_slot(nxt, 1'b0);
      old_slot = m_from[nxt];
      set_event(21, 2'd0);
      @(negedge clk);
      ev_valid = 1'b0; rq_valid = 1'b0;
      chk("R10 same-cycle slot old", rs_data, old_slot);
      req(a_ptr(), 1'b0, '0, d); chk("R10 pointer next cycle", d, ADDR_W'(m_tos));
      req(a_slot(m_tos, 1'b0), 1'b0, '0, d); chk("R10 slot next cycle", d, m_from[m_tos]);
    end
    // R9: software writes leave everything unchanged
    req(a_slot(1, 1'b0), 1'b1, 32'hFFFF_FFFF, d); chk("R9 write response", d, m_from[1]);
    req(a_slot(2, 1'b1), 1'b1, 32'h1234_5678, d); chk("R9 write response", d, m_to[2]);
    req(a_ptr(), 1'b1, 32'h0000_0001, d);         chk("R9 pointer write response", d, ADDR_W'(m_tos));
    sweep("R9 after writes");
    // R8: no response without a request
    @(negedge clk);
    chk("R8 idle rs_valid", ADDR_W'(rs_valid), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule